// File: doc/BRIEF.md
# Packed Double to Signed Word Converter

This block takes two IEEE-754 double-precision numbers packed side by side in a 128-bit operand and turns each into a signed 32-bit integer. The two integers come out packed in a 64-bit result. Each lane rounds the same way, under a two-bit rounding mode that arrives with the operand. A lane whose input is NaN or infinite, or whose rounded value cannot be held in 32 bits, produces the integer-indefinite pattern 0x80000000 and raises its invalid flag. A lane whose result is in range but differs from the exact input raises its inexact flag.

Operands arrive on a valid/ready handshake. Each accepted operand gives one result one cycle later, held in a single output register stage. When the invalid-exception mask is clear and any lane is invalid, the block withholds its write-enable for that result and raises an exception output. Both kinds of flag also gather into sticky status bits, which only reset clears.

Top module: `pk_dbl_to_i32`

## Requirements
- R1: Input lane 0 is `in_data[63:0]` and input lane 1 is `in_data[127:64]`. Output lane 0 is `out_data[31:0]` and output lane 1 is `out_data[63:32]`, with lane i computed only from input lane i.
- R2: `rnd_mode` selects the rounding of inexact values: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward minus infinity, 2'b10 rounds toward plus infinity, and 2'b11 truncates toward zero.
- R3: A rounded value is representable when it lies in the range -2^31 to 2^31-1 inclusive. A value that rounds to exactly -2^31 is valid and yields 0x80000000 with the lane's invalid flag low.
- R4: A lane whose exponent field is all ones (NaN or infinity), or whose rounded value is out of range, outputs 0x80000000 and sets its bit of `lane_inv`. Bit i of `lane_inv` belongs to lane i.
- R5: Bit i of `lane_inx` is set when lane i is in range and its result differs from its exact input. An invalid lane never sets `lane_inx`.
- R6: With `inv_mask` low and at least one invalid lane, the result has `out_we` low and `out_exc` high. In every other case a valid result has `out_we` high and `out_exc` low. Both are low whenever `out_valid` is low.
- R7: Zero and denormal inputs of either sign give 0. The exception is a nonzero denormal rounded away from zero, which gives +1 under round-up for a positive input and -1 under round-down for a negative input. Nonzero denormals set inexact; zeros do not.
- R8: `sticky_inv` and `sticky_inx` become the OR of every accepted operation's lane invalid and inexact flags, from the cycle its result appears. Only reset clears them.
- R9: An operand is accepted on a clock edge where `in_valid` and `in_ready` are high. Its result appears with `out_valid` high after that edge. The result is held unchanged while `out_ready` is low, and `in_ready` equals `!out_valid || out_ready`.
- R10: While `rst_n` is low at a clock edge, `out_valid`, `out_we`, `out_exc` and both sticky bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block can take an operand |
| in_data | input | 128 | Two packed doubles |
| rnd_mode | input | 2 | Rounding mode for this operand |
| inv_mask | input | 1 | Invalid exception masked when high |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 64 | Two packed signed 32-bit integers |
| out_we | output | 1 | Result may be written |
| out_exc | output | 1 | Unmasked invalid exception |
| lane_inv | output | 2 | Per-lane invalid flags |
| lane_inx | output | 2 | Per-lane inexact flags |
| sticky_inv | output | 1 | Accumulated invalid |
| sticky_inx | output | 1 | Accumulated inexact |

## Verification
Exact halves of both signs (2.5, -2.5, 3.5, -0.5) are run under all four modes. They separate ties-to-even from the directed and truncating modes and expose a wrong tie direction. Values on each side of +2^31 and -2^31, including -2^31-0.5 and 2^31-0.5, show whether the range test is applied after rounding and whether -2^31 is accepted. NaN, both infinities, signed zeros and the smallest denormals, paired with ordinary values in the other lane, check that lanes stay independent and that the masked and unmasked invalid paths differ only in the write-enable and exception outputs. A stalled output with a second operand waiting checks that the result holds and that only one operand is taken.

// File: rtl/cvt_pkg.sv
// Package: shared constants and types for the packed double to int32 converter.
// Assumes IEEE-754 binary64 inputs and 32-bit signed integer results.
package cvt_pkg;

    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int DBL_W  = 1 + EXP_W + FRAC_W;
    localparam int INT_W  = 32;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    // exponent at which the integer point sits just below the mantissa LSB
    localparam int POINT_EXP = BIAS + FRAC_W;
    // smallest exponent whose magnitude reaches 2^INT_W (always out of range)
    localparam int BIG_EXP   = BIAS + INT_W;
    // right shifts above this value leave no integer bits and no guard bit
    localparam int MAX_SH    = 60;
    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_e;

    typedef struct packed {
        logic [INT_W-1:0] val;
        logic             inv;
        logic             inx;
    } lane_res_t;

endpackage

// File: rtl/cvt_align.sv
// Module: cvt_align
// Splits one double into sign, integer magnitude, guard and sticky bits.
// Flags inputs that are NaN/infinity or too large for any 32-bit result.
// Assumes the caller applies rounding; purely combinational.
module cvt_align
    import cvt_pkg::*;
(
    input  logic [DBL_W-1:0] dbl,
    output logic             sgn,
    output logic             special,
    output logic [INT_W-1:0] mag,
    output logic             guard,
    output logic             sticky
);

    localparam int MANT_W = FRAC_W + 1;
    localparam int WIDE_W = MANT_W + 64;

    logic [EXP_W-1:0]  exp_f;
    logic [MANT_W-1:0] mant;
    logic [EXP_W:0]    shamt;
    logic              tiny;
    logic [WIDE_W-1:0] shifted;

    // Purpose: decode fields and classify the exponent.
    always_comb begin
        sgn     = dbl[DBL_W-1];
        exp_f   = dbl[DBL_W-2:FRAC_W];
        mant    = {(|exp_f), dbl[FRAC_W-1:0]};
        special = (&exp_f) || (int'(exp_f) >= BIG_EXP);
        tiny    = int'(exp_f) < (POINT_EXP - MAX_SH);
        shamt   = (EXP_W+1)'(POINT_EXP) - {1'b0, exp_f};
    end

    // Purpose: shift the mantissa so the binary point sits at bit 64.
    always_comb begin
        shifted = '0;
        if (!tiny && !special)
            shifted = {mant, 64'b0} >> shamt[5:0];
    end

    // Purpose: pick integer part and rounding bits, tiny values go to sticky.
    always_comb begin
        if (tiny) begin
            mag    = '0;
            guard  = 1'b0;
            sticky = |mant;
        end else begin
            mag    = shifted[64 +: INT_W];
            guard  = shifted[63];
            sticky = |shifted[62:0];
        end
    end

endmodule

// File: rtl/cvt_round.sv
// Module: cvt_round
// Rounds an aligned magnitude under the selected mode, applies the sign,
// and performs the signed 32-bit range test after rounding.
// Assumes mag < 2^32 whenever special is low; purely combinational.
module cvt_round
    import cvt_pkg::*;
(
    input  logic             sgn,
    input  logic             special,
    input  logic [INT_W-1:0] mag,
    input  logic             guard,
    input  logic             sticky,
    input  rnd_e             mode,
    output lane_res_t        res
);

    logic             frac_nz;
    logic             bump;
    logic [INT_W:0]   sum;
    logic             ovf;
    logic [INT_W-1:0] signed_val;

    // Purpose: decide whether the magnitude moves up by one.
    always_comb begin
        frac_nz = guard | sticky;
        unique case (mode)
            RND_NEAR: bump = guard & (sticky | mag[0]);
            RND_DOWN: bump = sgn & frac_nz;
            RND_UP:   bump = ~sgn & frac_nz;
            default:  bump = 1'b0;
        endcase
    end

    // Purpose: add the increment and test the signed range.
    always_comb begin
        sum        = {1'b0, mag} + {{INT_W{1'b0}}, bump};
        ovf        = sgn ? (sum > {1'b0, INDEF}) : (sum >= {1'b0, INDEF});
        signed_val = sgn ? (~sum[INT_W-1:0] + 1'b1) : sum[INT_W-1:0];
    end

    // Purpose: assemble the lane result and its flags.
    always_comb begin
        res.inv = special | ovf;
        res.val = res.inv ? INDEF : signed_val;
        res.inx = ~res.inv & frac_nz;
    end

endmodule

// File: rtl/cvt_lane.sv
// Module: cvt_lane
// One conversion lane: alignment followed by rounding and range check.
// Assumes both lanes share the rounding mode; purely combinational.
module cvt_lane
    import cvt_pkg::*;
(
    input  logic [DBL_W-1:0] dbl,
    input  rnd_e             mode,
    output lane_res_t        res
);

    logic             sgn;
    logic             special;
    logic [INT_W-1:0] mag;
    logic             guard;
    logic             sticky;

    cvt_align u_align (
        .dbl     (dbl),
        .sgn     (sgn),
        .special (special),
        .mag     (mag),
        .guard   (guard),
        .sticky  (sticky)
    );

    cvt_round u_round (
        .sgn     (sgn),
        .special (special),
        .mag     (mag),
        .guard   (guard),
        .sticky  (sticky),
        .mode    (mode),
        .res     (res)
    );

endmodule

// File: rtl/pk_dbl_to_i32.sv
// Module: pk_dbl_to_i32
// Converts LANES packed doubles to LANES packed signed 32-bit integers.
// One output register stage behind a valid/ready handshake. Sticky flags
// are cleared only by the synchronous active-low reset.
module pk_dbl_to_i32
    import cvt_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*64-1:0]    in_data,
    input  logic [1:0]             rnd_mode,
    input  logic                   inv_mask,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LANES*32-1:0]    out_data,
    output logic                   out_we,
    output logic                   out_exc,
    output logic [LANES-1:0]       lane_inv,
    output logic [LANES-1:0]       lane_inx,
    output logic                   sticky_inv,
    output logic                   sticky_inx
);

    localparam int IN_W  = LANES * DBL_W;
    localparam int OUT_W = LANES * INT_W;

    lane_res_t        res [LANES];
    logic [OUT_W-1:0] data_c;
    logic [LANES-1:0] inv_c;
    logic [LANES-1:0] inx_c;
    logic             take;
    logic             exc_c;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cvt_lane u_lane (
            .dbl  (in_data[g*DBL_W +: DBL_W]),
            .mode (rnd_e'(rnd_mode)),
            .res  (res[g])
        );
        assign data_c[g*INT_W +: INT_W] = res[g].val;
        assign inv_c[g] = res[g].inv;
        assign inx_c[g] = res[g].inx;
    end

    // Purpose: handshake and unmasked exception decision.
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready;
        exc_c    = !inv_mask && (|inv_c);
    end

    // Purpose: output stage control bits and sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_we     <= 1'b0;
            out_exc    <= 1'b0;
            sticky_inv <= 1'b0;
            sticky_inx <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            out_we    <= in_valid && !exc_c;
            out_exc   <= in_valid && exc_c;
            if (take) begin
                sticky_inv <= sticky_inv | (|inv_c);
                sticky_inx <= sticky_inx | (|inx_c);
            end
        end
    end

    // Purpose: output stage data and per-lane flags, loaded on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            lane_inv <= '0;
            lane_inx <= '0;
        end else if (take) begin
            out_data <= data_c;
            lane_inv <= inv_c;
            lane_inx <= inx_c;
        end
    end

    // R9: stalled result is held unchanged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(lane_inv));

    // R9: an empty output stage always takes an operand
    a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R6: exception output only with a result and never alongside write-enable
    a_r6_exc: assert property (@(posedge clk) disable iff (!rst_n)
        out_exc |-> out_valid && !out_we);

    // R4: an invalid lane 0 carries the indefinite pattern
    a_r4_indef0: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && lane_inv[0] |-> out_data[INT_W-1:0] == INDEF);

    // R5: invalid and inexact never together in a lane
    a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lane_inv & lane_inx) == '0);

    // R8: sticky flags never fall outside reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sticky_inv) && !$fell(sticky_inx));

endmodule

// File: tb/pk_dbl_to_i32_test.sv
`timescale 1ns/1ps
module pk_dbl_to_i32_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic [1:0]   rnd_mode = 2'b00;
    logic         inv_mask = 1'b1;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [63:0]  out_data;
    logic         out_we;
    logic         out_exc;
    logic [1:0]   lane_inv;
    logic [1:0]   lane_inx;
    logic         sticky_inv;
    logic         sticky_inx;

    int checks = 0;
    int failures = 0;

    localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] PDEN = 64'h0000_0000_0000_0001;
    localparam logic [63:0] NDEN = 64'h8000_0000_0000_0001;
    localparam logic [63:0] PZER = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZER = 64'h8000_0000_0000_0000;

    always #2.5 clk = ~clk;

    pk_dbl_to_i32 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .rnd_mode(rnd_mode), .inv_mask(inv_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_we(out_we), .out_exc(out_exc), .lane_inv(lane_inv),
        .lane_inx(lane_inx), .sticky_inv(sticky_inv), .sticky_inx(sticky_inx)
    );

    function automatic logic [63:0] dbl(input real r);
        return $realtobits(r);
    endfunction

    // behavioural rounding of a real under the mode encoding of R2
    function automatic real round_ref(input real x, input logic [1:0] m);
        real fl;
        real fr;
        fl = $floor(x);
        fr = x - fl;
        case (m)
            2'b00: begin
                if (fr > 0.5) return fl + 1.0;
                if (fr < 0.5) return fl;
                return ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
            end
            2'b01: return fl;
            2'b10: return (fr > 0.0) ? fl + 1.0 : fl;
            default: return (x < 0.0 && fr > 0.0) ? fl + 1.0 : fl;
        endcase
    endfunction

    // returns {inv, inx, value} for one lane
    function automatic logic [33:0] lane_ref(input logic [63:0] b, input logic [1:0] m);
        real x;
        real rr;
        int  v;
        if (b[62:52] == 11'h7FF) return {2'b10, 32'h8000_0000};
        x  = $bitstoreal(b);
        rr = round_ref(x, m);
        if (rr < -2147483648.0 || rr > 2147483647.0) return {2'b10, 32'h8000_0000};
        v = $rtoi(rr);
        return {1'b0, (rr != x), v};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // issue one operand with out_ready high and check the result one cycle later
    task automatic run_op(input string req, input logic [63:0] l1, input logic [63:0] l0,
                          input logic [1:0] m, input logic mask);
        logic [33:0] e0;
        logic [33:0] e1;
        logic        exc;
        e0 = lane_ref(l0, m);
        e1 = lane_ref(l1, m);
        exc = !mask && (e0[33] || e1[33]);
        @(negedge clk);
        in_data = {l1, l0}; rnd_mode = m; inv_mask = mask; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", {63'b0, out_valid}, 64'd1);
        check(req, "R1 lanes data", out_data, {e1[31:0], e0[31:0]});
        check(req, "R4/R5 lane flags", {60'b0, lane_inv, lane_inx},
              {60'b0, e1[33], e0[33], e1[32], e0[32]});
        check(req, "R6 we/exc", {62'b0, out_we, out_exc}, {62'b0, !exc, exc});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", "reset outputs", {59'b0, out_valid, out_we, out_exc, sticky_inv, sticky_inx}, 64'd0);
        check("R9", "in_ready in reset", {63'b0, in_ready}, 64'd1);
        rst_n = 1'b1;
    endtask

    task automatic t_ties();
        real vals [8] = '{2.5, -2.5, 3.5, -0.5, 1.25, -1.75, 0.5, 7.0};
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 8; i += 2)
                run_op("R2", dbl(vals[i+1]), dbl(vals[i]), 2'(m), 1'b1);
    endtask

    task automatic t_bounds();
        real vals [10] = '{2147483647.0, 2147483647.5, -2147483648.0, -2147483648.5,
                           -2147483649.0, 2147483648.0, 2147483646.5, -2147483648.9,
                           -2147483647.5, 1.0e300};
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 10; i += 2)
                run_op("R3", dbl(vals[i]), dbl(vals[i+1]), 2'(m), 1'b1);
        // R3: exactly -2^31 is valid in both lanes
        run_op("R3", dbl(-2147483648.0), dbl(-2147483648.0), 2'b00, 1'b0);
    endtask

    task automatic t_special();
        run_op("R4", QNAN, dbl(5.5), 2'b00, 1'b1);
        run_op("R4", dbl(-9.25), PINF, 2'b01, 1'b1);
        run_op("R4", NINF, QNAN, 2'b10, 1'b1);
        run_op("R1", dbl(100.0), dbl(-3.0), 2'b11, 1'b1);
    endtask

    task automatic t_denorm();
        for (int m = 0; m < 4; m++) begin
            run_op("R7", NDEN, PDEN, 2'(m), 1'b1);
            run_op("R7", NZER, PZER, 2'(m), 1'b1);
        end
    endtask

    task automatic t_mask();
        run_op("R6", QNAN, dbl(1.0), 2'b00, 1'b0);
        run_op("R6", dbl(2.0), dbl(4.0e10), 2'b11, 1'b0);
        run_op("R6", dbl(2.5), dbl(-1.5), 2'b00, 1'b0);
        run_op("R6", PINF, dbl(1.0), 2'b00, 1'b1);
    endtask

    task automatic t_sticky();
        do_reset();
        run_op("R8", dbl(3.0), dbl(4.0), 2'b00, 1'b1);
        check("R8", "sticky after exact", {62'b0, sticky_inv, sticky_inx}, 64'd0);
        run_op("R8", dbl(3.0), dbl(2.5), 2'b00, 1'b1);
        check("R8", "sticky inexact set", {62'b0, sticky_inv, sticky_inx}, 64'd1);
        run_op("R8", QNAN, dbl(4.0), 2'b00, 1'b1);
        check("R8", "sticky invalid set", {62'b0, sticky_inv, sticky_inx}, 64'd3);
        run_op("R8", dbl(1.0), dbl(4.0), 2'b00, 1'b1);
        check("R8", "sticky held", {62'b0, sticky_inv, sticky_inx}, 64'd3);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        in_data = {dbl(11.0), dbl(-12.0)}; rnd_mode = 2'b00; inv_mask = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_data = {dbl(21.0), dbl(-22.0)};
        check("R9", "first result", out_data, {32'd11, -32'sd12});
        check("R9", "ready low when stalled", {62'b0, in_ready, out_valid}, 64'd1);
        repeat (3) @(negedge clk);
        check("R9", "held while stalled", out_data, {32'd11, -32'sd12});
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "second result", out_data, {32'd21, -32'sd22});
        check("R9", "valid second", {63'b0, out_valid}, 64'd1);
        @(negedge clk);
        check("R9", "drained", {63'b0, out_valid}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_ties();
        t_bounds();
        t_special();
        t_denorm();
        t_mask();
        t_sticky();
        t_backpressure();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule